// File: doc/BRIEF.md
# Fixed-Point Rounding and Saturation Stage

This block narrows a signed two's-complement fixed-point sample in one datapath stage. It drops `N` fraction bits using one of eight rounding modes, chosen at run time. It can then fold the rounding carry back into range, clip `M` surplus integer bits with saturation, and remove the most negative code so that the range is symmetric. It is meant to sit at the end of a filter or accumulator chain, where a wide intermediate result must be brought down to a storage or interface width without wrap-around.

Four parameters shape the result width and the clamping. `ALIGN` keeps or removes the carry bit, `SYM` turns on symmetric clamping, and `REG_OUT` selects a registered or purely combinational output. A single flag reports every sample whose value was changed by any clamp. Rounding itself never raises the flag.

Top module: `fxr_narrow`

## Requirements
- R1: `mode_in` is a 3-bit code. Code 0 rounds toward minus infinity, floor(x). Code 1 rounds toward zero, sign(x)*floor(|x|). In both cases x is the input divided by 2^N.
- R2: Code 2 rounds toward plus infinity, ceil(x). Code 3 rounds away from zero, sign(x)*ceil(|x|).
- R3: Code 4 computes floor(x+0.5), so ties go upward. Code 5 computes ceil(x-0.5), so ties go downward.
- R4: Code 6 computes sign(x)*ceil(|x|-0.5), so ties go toward zero. Code 7 computes sign(x)*floor(|x|+0.5), so ties go away from zero: 1.5→2, 2.5→3, −1.5→−2, −2.5→−3.
- R5: With N>0 and `ALIGN`=0 the rounded value is W−N+1 bits wide. This lets a carry out of the integer part, such as ceil(127/8)=16, be represented exactly. The two floor-type modes always fit in W−N bits and appear sign-extended.
- R6: With `ALIGN`=1 and N>0 the rounded value is saturated to W−N bits, giving the same result as rounding without `ALIGN` followed by a 1-bit saturation.
- R7: With M>0 the rounded value is saturated by M high bits. Values outside the output range become the most positive or most negative output code instead of being truncated.
- R8: With `SYM`=1 the most negative output code never appears. It is replaced by that code plus one, so the range becomes −(2^(k−1)−1) to 2^(k−1)−1.
- R9: `sat_flag` is 1 exactly for the results whose value was changed by carry alignment, high-bit saturation or symmetric clamping.
- R10: With N=0 the input passes through unrounded in every mode. With M=0 no high-bit saturation takes place.
- R11: With `REG_OUT`=1 the result and flag appear one clock after the input. With `REG_OUT`=0 they follow the input in the same cycle.
- R12: With `REG_OUT`=1 a synchronous active-high `srst` clears `res_out` and `sat_flag` to zero on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| srst | input | 1 | Synchronous reset, active high |
| x_in | input | W | Signed input sample with N fraction bits |
| mode_in | input | 3 | Rounding mode code (R1 to R4) |
| res_out | output | W−N+(N>0 and ALIGN=0 ? 1 : 0)−M | Signed narrowed result |
| sat_flag | output | 1 | Result was changed by a clamp |

## Verification
A wrong increment decision in the rounding core shows up as an output one step off, but only on inputs with a particular fraction pattern and sign. For that reason every input code is paired with every mode, and the output is compared against a reference built from real-valued floor and ceil. A stuck or misplaced range test in a saturation stage shows up as a wrapped value or a missing flag at the first out-of-range sample. These faults appear at the ports one cycle after the input in the registered variants and in the same cycle in the combinational one. Configurations with and without carry alignment, symmetry, rounding and clipping run side by side, so that each range boundary is reached.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int MODE_W = 3;

    // Rounding mode codes; the numeric order is part of the port contract.
    typedef enum logic [MODE_W-1:0] {
        RM_FLOOR      = 3'd0,
        RM_TRUNC_ZERO = 3'd1,
        RM_CEIL       = 3'd2,
        RM_CEIL_OUT   = 3'd3,
        RM_HALF_UP    = 3'd4,
        RM_HALF_DOWN  = 3'd5,
        RM_HALF_ZERO  = 3'd6,
        RM_HALF_OUT   = 3'd7
    } rnd_mode_e;

    // Fraction classification handed from the splitter to the decision logic.
    typedef struct packed {
        logic neg;      // sign of the sample
        logic nonzero;  // any dropped bit set
        logic ge_half;  // dropped part >= one half
        logic gt_half;  // dropped part >  one half
    } frac_info_t;

endpackage

// File: rtl/fxr_round.sv
// Removes N low bits from a signed sample. The result carries one extra
// integer bit so that an upward step out of the largest value stays exact.
module fxr_round
    import fxr_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 3,
    localparam int RW0 = (N > 0) ? W - N + 1 : W
) (
    input  logic [W-1:0]      x_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic [RW0-1:0]    r_out
);

    generate
        if (N == 0) begin : g_pass
            // Nothing to drop: every mode is the identity.
            logic [MODE_W-1:0] mode_unused;
            assign mode_unused = mode_in;
            assign r_out       = x_in;
        end else begin : g_round
            localparam int QW = W - N;
            localparam logic [N-1:0] HALF = N'(1 << (N - 1));

            logic [QW-1:0] quo;
            logic [N-1:0]  frac;
            frac_info_t    fi;
            logic          inc;

            assign quo  = x_in[W-1:N];
            assign frac = x_in[N-1:0];

            always_comb begin
                fi.neg     = x_in[W-1];
                fi.nonzero = |frac;
                fi.ge_half = frac[N-1];
                fi.gt_half = frac > HALF;
            end

            // The floor quotient is always the base; each mode only decides
            // whether one unit is added on top of it.
            always_comb begin
                unique case (rnd_mode_e'(mode_in))
                    RM_FLOOR:      inc = 1'b0;
                    RM_TRUNC_ZERO: inc = fi.neg & fi.nonzero;
                    RM_CEIL:       inc = fi.nonzero;
                    RM_CEIL_OUT:   inc = ~fi.neg & fi.nonzero;
                    RM_HALF_UP:    inc = fi.ge_half;
                    RM_HALF_DOWN:  inc = fi.gt_half;
                    RM_HALF_ZERO:  inc = fi.neg ? fi.ge_half : fi.gt_half;
                    RM_HALF_OUT:   inc = fi.neg ? fi.gt_half : fi.ge_half;
                    default:       inc = 1'b0;
                endcase
            end

            assign r_out = {quo[QW-1], quo} + RW0'(inc);
        end
    endgenerate

endmodule

// File: rtl/fxr_sat.sv
// Clips CUT high bits from a signed value, clamping to the extreme codes.
module fxr_sat #(
    parameter int IW  = 8,
    parameter int CUT = 1,
    localparam int OW = IW - CUT
) (
    input  logic [IW-1:0] v_in,
    output logic [OW-1:0] v_out,
    output logic          clipped
);

    generate
        if (CUT == 0) begin : g_none
            assign v_out   = v_in;
            assign clipped = 1'b0;
        end else begin : g_clip
            localparam logic [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
            localparam logic [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

            logic [CUT:0] head;
            logic         fits;

            // The value fits when the dropped bits repeat the kept sign bit.
            assign head    = v_in[IW-1:OW-1];
            assign fits    = (&head) | ~(|head);
            assign clipped = ~fits;

            always_comb begin
                if (fits)            v_out = v_in[OW-1:0];
                else if (v_in[IW-1]) v_out = MINV;
                else                 v_out = MAXV;
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_sym.sv
// Optionally removes the most negative code from a signed value.
module fxr_sym #(
    parameter int OW = 5,
    parameter bit EN = 1'b0
) (
    input  logic [OW-1:0] v_in,
    output logic [OW-1:0] v_out,
    output logic          clamped
);

    generate
        if (EN) begin : g_on
            localparam logic [OW-1:0] MINV = OW'(1) << (OW - 1);
            logic hit;
            assign hit     = (v_in == MINV);
            assign clamped = hit;
            assign v_out   = hit ? MINV + OW'(1) : v_in;
        end else begin : g_off
            assign v_out   = v_in;
            assign clamped = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fxr_narrow.sv
// Round, align, clip and symmetrise a signed sample in one stage.
module fxr_narrow
    import fxr_pkg::*;
#(
    parameter int W       = 8,
    parameter int N       = 3,
    parameter int M       = 1,
    parameter bit ALIGN   = 1'b0,
    parameter bit SYM     = 1'b0,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic [W-1:0]         x_in,
    input  logic [MODE_W-1:0]    mode_in,
    output logic [W-N+(((N > 0) && !ALIGN) ? 1 : 0)-M-1:0] res_out,
    output logic                 sat_flag
);

    localparam int RW0       = (N > 0) ? W - N + 1 : W;
    localparam int ALIGN_CUT = (ALIGN && (N > 0)) ? 1 : 0;
    localparam int RW        = RW0 - ALIGN_CUT;
    localparam int OW        = RW - M;

    typedef struct packed {
        logic [OW-1:0] res;
        logic          sat;
    } stage_t;

    logic [RW0-1:0] rounded;
    logic [RW-1:0]  aligned;
    logic [OW-1:0]  clipped_v;
    logic [OW-1:0]  final_v;
    logic           f_align, f_clip, f_sym;

    stage_t out_d, out_q;

    fxr_round #(.W(W), .N(N)) u_round (
        .x_in    (x_in),
        .mode_in (mode_in),
        .r_out   (rounded)
    );

    // Carry alignment is a one-bit saturation of the rounded value.
    fxr_sat #(.IW(RW0), .CUT(ALIGN_CUT)) u_align (
        .v_in    (rounded),
        .v_out   (aligned),
        .clipped (f_align)
    );

    fxr_sat #(.IW(RW), .CUT(M)) u_clip (
        .v_in    (aligned),
        .v_out   (clipped_v),
        .clipped (f_clip)
    );

    fxr_sym #(.OW(OW), .EN(SYM)) u_sym (
        .v_in    (clipped_v),
        .v_out   (final_v),
        .clamped (f_sym)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = final_v;
        out_d.sat = f_align | f_clip | f_sym;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (srst) out_q <= '0;
                else      out_q <= out_d;
            end
        end else begin : g_comb
            logic unused_ctl;
            assign unused_ctl = clk ^ srst;
            assign out_q      = out_d;
        end
    endgenerate

    assign res_out  = out_q.res;
    assign sat_flag = out_q.sat;

endmodule

// File: rtl/fxr_narrow_chk.sv
// Port-level properties of the narrowing stage.
module fxr_narrow_chk #(
    parameter int W       = 8,
    parameter int N       = 3,
    parameter int M       = 1,
    parameter bit ALIGN   = 1'b0,
    parameter bit SYM     = 1'b0,
    parameter bit REG_OUT = 1'b1,
    localparam int RW0    = (N > 0) ? W - N + 1 : W,
    localparam int OW     = RW0 - ((ALIGN && (N > 0)) ? 1 : 0) - M
) (
    input logic          clk,
    input logic          srst,
    input logic [W-1:0]  x_in,
    input logic [2:0]    mode_in,
    input logic [OW-1:0] res_out,
    input logic          sat_flag
);

    localparam logic [OW-1:0] MAXV    = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] MINV    = OW'(1) << (OW - 1);
    localparam logic [OW-1:0] LOW_END = SYM ? MINV + OW'(1) : MINV;

    // R9: a flagged result always sits on a clamp boundary.
    p_flag_at_edge_r9: assert property (@(posedge clk) disable iff (srst)
        sat_flag |-> (res_out == MAXV || res_out == LOW_END));

    generate
        if (SYM) begin : g_sym
            // R8: the most negative code is never produced.
            p_no_min_code_r8: assert property (@(posedge clk) disable iff (srst)
                res_out != MINV);
        end

        if (REG_OUT) begin : g_reg
            // R12: reset empties the output register.
            p_reset_clear_r12: assert property (@(posedge clk)
                srst |=> (res_out == '0 && !sat_flag));
            // R11: an unchanged input yields an unchanged registered output.
            p_hold_r11: assert property (@(posedge clk) disable iff (srst)
                (!$past(srst) && $stable(x_in) && $stable(mode_in))
                |=> ($stable(res_out) && $stable(sat_flag)));
        end

        if (N == 0 && M == 0 && !SYM) begin : g_pass
            if (REG_OUT) begin : g_pr
                // R10: identity path, one cycle late.
                p_passthru_r10: assert property (@(posedge clk) disable iff (srst)
                    !$past(srst) |-> (res_out == OW'($past(x_in)) && !sat_flag));
            end else begin : g_pc
                // R10: identity path, same cycle.
                p_passthru_r10: assert property (@(posedge clk) disable iff (srst)
                    (res_out == OW'(x_in) && !sat_flag));
            end
        end
    endgenerate

endmodule

bind fxr_narrow fxr_narrow_chk #(
    .W(W), .N(N), .M(M), .ALIGN(ALIGN), .SYM(SYM), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_fxr_narrow.sv
`timescale 1ns/1ps
module sim_fxr_narrow;

    logic       clk = 1'b0;
    logic       srst;
    logic [7:0] x;
    logic [2:0] mode;

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // u0: W8 N3 M0, carry kept, registered  -> 6 bits
    // u1: W8 N3 M2, align, sym, comb        -> 3 bits
    // u2: W8 N0 M0, registered              -> 8 bits
    // u3: W8 N2 M0, align, sym, registered  -> 6 bits
    // u4: W8 N2 M3, carry kept, registered  -> 4 bits
    logic signed [5:0] u0_res; logic u0_f;
    logic signed [2:0] u1_res; logic u1_f;
    logic signed [7:0] u2_res; logic u2_f;
    logic signed [5:0] u3_res; logic u3_f;
    logic signed [3:0] u4_res; logic u4_f;

    fxr_narrow #(.W(8), .N(3), .M(0), .ALIGN(0), .SYM(0), .REG_OUT(1)) u0 (
        .clk(clk), .srst(srst), .x_in(x), .mode_in(mode), .res_out(u0_res), .sat_flag(u0_f));
    fxr_narrow #(.W(8), .N(3), .M(2), .ALIGN(1), .SYM(1), .REG_OUT(0)) u1 (
        .clk(clk), .srst(srst), .x_in(x), .mode_in(mode), .res_out(u1_res), .sat_flag(u1_f));
    fxr_narrow #(.W(8), .N(0), .M(0), .ALIGN(0), .SYM(0), .REG_OUT(1)) u2 (
        .clk(clk), .srst(srst), .x_in(x), .mode_in(mode), .res_out(u2_res), .sat_flag(u2_f));
    fxr_narrow #(.W(8), .N(2), .M(0), .ALIGN(1), .SYM(1), .REG_OUT(1)) u3 (
        .clk(clk), .srst(srst), .x_in(x), .mode_in(mode), .res_out(u3_res), .sat_flag(u3_f));
    fxr_narrow #(.W(8), .N(2), .M(3), .ALIGN(0), .SYM(0), .REG_OUT(1)) u4 (
        .clk(clk), .srst(srst), .x_in(x), .mode_in(mode), .res_out(u4_res), .sat_flag(u4_f));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference rounding on the real value x / 2^n.
    function automatic int ref_round(input int xv, input int md, input int n);
        real v, a, s, r;
        v = xv / (2.0 ** n);
        a = (v < 0.0) ? -v : v;
        s = (v < 0.0) ? -1.0 : 1.0;
        case (md)
            0: r = $floor(v);
            1: r = s * $floor(a);
            2: r = $ceil(v);
            3: r = s * $ceil(a);
            4: r = $floor(v + 0.5);
            5: r = $ceil(v - 0.5);
            6: r = s * $ceil(a - 0.5);
            default: r = s * $floor(a + 0.5);
        endcase
        return int'(r);
    endfunction

    function automatic int clamp(input int v, input int bits, input int sy);
        int hi, lo;
        hi = (1 << (bits - 1)) - 1;
        lo = -(1 << (bits - 1)) + sy;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic expect_one(input string who, input int act_r, input int act_f,
                              input int xv, input int md, input int n, input int al,
                              input int m, input int sy);
        int rw, ow, r, t;
        string tag;
        rw = (n > 0) ? ((al != 0) ? 8 - n : 9 - n) : 8;
        ow = rw - m;
        r  = ref_round(xv, md, n);
        t  = r;
        if (al != 0 && n > 0) t = clamp(t, 8 - n, 0);   // R6
        t = clamp(t, ow, 0);                             // R7
        if (sy != 0) t = clamp(t, ow, 1);                // R8
        case (md)
            0, 1: tag = "R1";
            2, 3: tag = "R2";
            4, 5: tag = "R3";
            default: tag = "R4";
        endcase
        chk($sformatf("%s %s x=%0d mode=%0d res", tag, who, xv, md), act_r, t);
        chk($sformatf("R9 %s x=%0d mode=%0d flag", who, xv, md), act_f, int'(t != r));
    endtask

    task automatic drive(input int xv, input int md);
        @(negedge clk);
        x    = 8'(xv);
        mode = 3'(md);
        @(negedge clk);
    endtask

    task automatic t_reset();
        srst = 1'b1;
        x    = 8'd127;
        mode = 3'd7;
        repeat (3) @(negedge clk);
        chk("R12 reset u0 res", int'(u0_res), 0);
        chk("R12 reset u0 flag", int'(u0_f), 0);
        chk("R12 reset u4 res", int'(u4_res), 0);
        chk("R12 reset u4 flag", int'(u4_f), 0);
        srst = 1'b0;
    endtask

    task automatic t_ties();
        drive(12, 7);  chk("R4 1.5 away", int'(u0_res), 2);
        drive(20, 7);  chk("R4 2.5 away", int'(u0_res), 3);
        drive(-12, 7); chk("R4 -1.5 away", int'(u0_res), -2);
        drive(-20, 7); chk("R4 -2.5 away", int'(u0_res), -3);
        drive(-12, 4); chk("R3 -1.5 half up", int'(u0_res), -1);
        drive(-12, 6); chk("R4 -1.5 to zero", int'(u0_res), -1);
        drive(20, 5);  chk("R3 2.5 half down", int'(u0_res), 2);
    endtask

    task automatic t_edges();
        drive(127, 2);
        chk("R5 carry kept", int'(u0_res), 16);
        chk("R5 carry no flag", int'(u0_f), 0);
        chk("R6 carry folded", int'(u3_res), 31);
        chk("R6 fold flag", int'(u3_f), 1);
        chk("R7 clip high", int'(u4_res), 7);
        drive(-128, 0);
        chk("R7 clip low", int'(u4_res), -8);
        chk("R7 clip flag", int'(u4_f), 1);
        chk("R8 sym low", int'(u3_res), -31);
        chk("R8 sym flag", int'(u3_f), 1);
        chk("R10 pass low", int'(u2_res), -128);
        drive(13, 7);
        chk("R10 no rounding", int'(u2_res), 13);
        chk("R10 no flag", int'(u2_f), 0);
    endtask

    task automatic t_latency();
        drive(40, 0);
        @(negedge clk);
        x    = 8'(-40);
        mode = 3'd0;
        #1;
        chk("R11 reg holds old", int'(u0_res), 5);
        chk("R11 comb follows", int'(u1_res), -3);
        chk("R11 comb flag", int'(u1_f), 1);
        @(negedge clk);
        chk("R11 reg updated", int'(u0_res), -5);
    endtask

    task automatic t_reset_mid();
        drive(127, 7);
        @(negedge clk);
        srst = 1'b1;
        @(negedge clk);
        chk("R12 mid reset res", int'(u3_res), 0);
        chk("R12 mid reset flag", int'(u3_f), 0);
        srst = 1'b0;
    endtask

    task automatic t_sweep();
        for (int md = 0; md < 8; md++) begin
            for (int xv = -128; xv < 128; xv++) begin
                drive(xv, md);
                expect_one("u0", int'(u0_res), int'(u0_f), xv, md, 3, 0, 0, 0);
                expect_one("u1", int'(u1_res), int'(u1_f), xv, md, 3, 1, 2, 1);
                expect_one("u2", int'(u2_res), int'(u2_f), xv, md, 0, 0, 0, 0);
                expect_one("u3", int'(u3_res), int'(u3_f), xv, md, 2, 1, 0, 1);
                expect_one("u4", int'(u4_res), int'(u4_f), xv, md, 2, 0, 3, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ties();
        t_edges();
        t_latency();
        t_reset_mid();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule